// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

This block is the configuration receiver for one device in a chain of programmable parts. All parts in the chain share a single byte-wide data bus and a common externally driven configuration clock. On each rising clock edge the receiver takes a whole byte. It checks and decodes a six-byte header, and then stores frame bytes into a modelled configuration memory that is written eight bits at a time. No serialisation takes place.

Every device on the bus decodes the header, whatever the level of its select input. After the header, a device stores bytes only while it is selected and its memory still has room. Each device drives a chain output that its downstream neighbour uses as a select. The output is released low a fixed number of internal-oscillator ticks after the init signal is seen high. It goes high again once the memory is full, which hands the bus to the next device.

A DONE line is modelled as an open-drain pull-down enable. It is released a fixed number of clock edges after the memory fills. A header constant that does not match the expected value latches a sticky error. The error blocks all further writes and keeps DONE pulled low until reset.

Top module: `cfgChainLoader`

## Requirements
- R1: While reset is asserted and just after it, chainOut is 1, doneDriveLow is 1, hdrErr is 0 and memFull is 0.
- R2: The first clock edge with initHigh sampled at 1 records init. chainOut stays 1 until the second later edge on which oscTick is 1. After that edge it reads 0.
- R3: Bytes presented while initHigh is low are ignored. The first edge that samples initHigh at 1 only starts loading and does not sample dataIn. Header bytes are taken one per edge starting at the following edge.
- R4: The header is 0xFF, then 0xF2, then a 24-bit length sent most significant byte first, then 0xFF. lenCount shows the parsed length from the edge that takes its last byte.
- R5: The header is decoded identically whether selIn is 0 or 1.
- R6: After the header, a byte is written at the next address, starting from 0, on each edge where selIn is 1. A byte presented with selIn at 0 is not stored. Memory contents are visible at rdData for address rdAddr.
- R7: Once MEM_BYTES bytes are stored, memFull and chainOut are 1 and further bytes are not stored. The parsed length count plays no part in this.
- R8: doneDriveLow goes to 0 after exactly STARTUP_CYCLES edges following the edge that stored the last byte.
- R9: A wrong constant header byte sets hdrErr at that edge. A wrong constant is header byte 0 or 5 not equal to 0xFF, or byte 1 not equal to 0xF2. hdrErr stays 1, no byte is stored afterwards, and doneDriveLow stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | External configuration clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle enable marking an internal-oscillator tick |
| initHigh | input | 1 | Init signal observed high |
| selIn | input | 1 | Chip select from the previous device's chain output |
| dataIn | input | 8 | Shared configuration data byte |
| rdAddr | input | AW | Read address into the modelled configuration memory |
| rdData | output | 8 | Memory byte at rdAddr |
| lenCount | output | 24 | Parsed header length count |
| memFull | output | 1 | Configuration memory full |
| chainOut | output | 1 | Chain status output to the next device |
| doneDriveLow | output | 1 | 1 = pull the open-drain DONE line low |
| hdrErr | output | 1 | Sticky header constant mismatch flag |

## Verification
Every flag and count is registered once, so its new value is due right after the edge that took the byte. The exceptions are the DONE release, which comes STARTUP_CYCLES edges after memFull, and chainOut, which is a decode of two registers with no added delay. The bench drives each byte 1 ns after a rising edge and samples 1 ns after the following edge. In its reference model it counts edges from the byte that filled the memory, and checks DONE on each of those edges. Memory contents are read back combinationally through rdAddr after the stimulus has stopped.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] SYNC_BYTE = 8'hF2;
  localparam int unsigned HDR_BYTES = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FRAME,
    ST_START,
    ST_DONE,
    ST_FAULT
  } loadState_t;

  typedef struct packed {
    logic lenShift;
    logic memWrite;
  } dpStrobe_t;
endpackage

// File: rtl/cfgload_dp.sv
module cfgload_dp
  import cfgload_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 16,
  parameter int unsigned LEN_W     = 24,
  localparam int unsigned AW       = $clog2(MEM_BYTES),
  localparam int unsigned CW       = $clog2(MEM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       dataIn,
  input  logic [AW-1:0]    rdAddr,
  output logic [7:0]       rdData,
  output logic [LEN_W-1:0] lenCount,
  output logic             memFull,
  output logic             byteIsFill,
  output logic             byteIsSync
);
  logic [7:0]       cfgMem [MEM_BYTES];
  logic [CW-1:0]    wrCnt;
  logic [LEN_W-1:0] lenReg;
  logic             fullReg;

  assign byteIsFill = (dataIn == FILL_BYTE);
  assign byteIsSync = (dataIn == SYNC_BYTE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
    end else if (strobe.lenShift) begin
      lenReg <= {lenReg[LEN_W-9:0], dataIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt   <= '0;
      fullReg <= 1'b0;
    end else if (strobe.memWrite && !fullReg) begin
      wrCnt   <= wrCnt + 1'b1;
      fullReg <= (wrCnt == CW'(MEM_BYTES - 1));
    end
  end

  // the memory holds its contents through reset, like a real array
  always_ff @(posedge clk) begin
    if (strobe.memWrite && !fullReg) begin
      cfgMem[wrCnt[AW-1:0]] <= dataIn;
    end
  end

  assign rdData   = cfgMem[rdAddr];
  assign lenCount = lenReg;
  assign memFull  = fullReg;
endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int unsigned TICK_DELAY     = 2,
  parameter int unsigned STARTUP_CYCLES = 5,
  localparam int unsigned TW = $clog2(TICK_DELAY + 1),
  localparam int unsigned SW = $clog2(STARTUP_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      oscTick,
  input  logic      initHigh,
  input  logic      selIn,
  input  logic      byteIsFill,
  input  logic      byteIsSync,
  input  logic      memFull,
  output dpStrobe_t strobe,
  output logic      chainOut,
  output logic      doneDriveLow,
  output logic      hdrErr
);
  loadState_t    state;
  logic [2:0]    hdrIdx;
  logic          initSeen;
  logic          armed;
  logic [TW-1:0] tickCnt;
  logic [SW-1:0] startCnt;
  logic          doneRel;
  logic          errReg;
  logic          hdrBad;

  always_comb begin
    hdrBad = 1'b0;
    if (state == ST_HDR) begin
      unique case (hdrIdx)
        3'd0, 3'(HDR_BYTES - 1): hdrBad = !byteIsFill;
        3'd1:                    hdrBad = !byteIsSync;
        default:                 hdrBad = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.lenShift = (state == ST_HDR) && (hdrIdx >= 3'd2) && (hdrIdx <= 3'd4);
    strobe.memWrite = (state == ST_FRAME) && selIn && !memFull;
  end

  // oscillator-tick delay that releases the chain output after init
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initSeen <= 1'b0;
      armed    <= 1'b0;
      tickCnt  <= '0;
    end else begin
      if (initHigh) initSeen <= 1'b1;
      if (initSeen && oscTick && !armed) begin
        tickCnt <= tickCnt + 1'b1;
        if (tickCnt == TW'(TICK_DELAY - 1)) armed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hdrIdx   <= '0;
      startCnt <= '0;
      doneRel  <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (initHigh) begin
            state  <= ST_HDR;
            hdrIdx <= '0;
          end
        end
        ST_HDR: begin
          if (hdrBad) begin
            errReg <= 1'b1;
            state  <= ST_FAULT;
          end else begin
            hdrIdx <= hdrIdx + 1'b1;
            if (hdrIdx == 3'(HDR_BYTES - 1)) state <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (memFull) begin
            startCnt <= SW'(1);
            if (STARTUP_CYCLES <= 1) begin
              doneRel <= 1'b1;
              state   <= ST_DONE;
            end else begin
              state   <= ST_START;
            end
          end
        end
        ST_START: begin
          startCnt <= startCnt + 1'b1;
          if (startCnt == SW'(STARTUP_CYCLES - 1)) begin
            doneRel <= 1'b1;
            state   <= ST_DONE;
          end
        end
        ST_DONE, ST_FAULT: state <= state;
        default: state <= ST_FAULT;
      endcase
    end
  end

  assign chainOut     = !armed || memFull;
  assign doneDriveLow = !doneRel || errReg;
  assign hdrErr       = errReg;
endmodule

// File: rtl/cfgChainLoader.sv
module cfgChainLoader
  import cfgload_pkg::*;
#(
  parameter int unsigned MEM_BYTES      = 16,
  parameter int unsigned TICK_DELAY     = 2,
  parameter int unsigned STARTUP_CYCLES = 5,
  localparam int unsigned AW    = $clog2(MEM_BYTES),
  localparam int unsigned LEN_W = 24
) (
  input  logic             cfgClk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             initHigh,
  input  logic             selIn,
  input  logic [7:0]       dataIn,
  input  logic [AW-1:0]    rdAddr,
  output logic [7:0]       rdData,
  output logic [LEN_W-1:0] lenCount,
  output logic             memFull,
  output logic             chainOut,
  output logic             doneDriveLow,
  output logic             hdrErr
);
  dpStrobe_t strobe;
  logic      byteIsFill;
  logic      byteIsSync;

  cfgload_ctrl #(
    .TICK_DELAY    (TICK_DELAY),
    .STARTUP_CYCLES(STARTUP_CYCLES)
  ) uCtrl (
    .clk         (cfgClk),
    .rstN        (rstN),
    .oscTick     (oscTick),
    .initHigh    (initHigh),
    .selIn       (selIn),
    .byteIsFill  (byteIsFill),
    .byteIsSync  (byteIsSync),
    .memFull     (memFull),
    .strobe      (strobe),
    .chainOut    (chainOut),
    .doneDriveLow(doneDriveLow),
    .hdrErr      (hdrErr)
  );

  cfgload_dp #(
    .MEM_BYTES(MEM_BYTES),
    .LEN_W    (LEN_W)
  ) uDp (
    .clk       (cfgClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .lenCount  (lenCount),
    .memFull   (memFull),
    .byteIsFill(byteIsFill),
    .byteIsSync(byteIsSync)
  );
endmodule

// File: rtl/cfgChainLoader_chk.sv
module cfgChainLoader_chk (
  input logic        cfgClk,
  input logic        rstN,
  input logic [23:0] lenCount,
  input logic        memFull,
  input logic        chainOut,
  input logic        doneDriveLow,
  input logic        hdrErr
);
  AST_ERR_HOLDS_DONE: assert property (@(posedge cfgClk) disable iff (!rstN)
    hdrErr |-> doneDriveLow); // R9
  AST_ERR_STICKY: assert property (@(posedge cfgClk) disable iff (!rstN)
    hdrErr |=> hdrErr); // R9
  AST_NO_FILL_AFTER_ERR: assert property (@(posedge cfgClk) disable iff (!rstN)
    memFull |-> !hdrErr); // R9
  AST_FULL_STICKY: assert property (@(posedge cfgClk) disable iff (!rstN)
    memFull |=> memFull); // R7
  AST_CHAIN_HIGH_FULL: assert property (@(posedge cfgClk) disable iff (!rstN)
    memFull |-> chainOut); // R7
  AST_DONE_AFTER_FULL: assert property (@(posedge cfgClk) disable iff (!rstN)
    !doneDriveLow |-> memFull); // R8
  AST_LEN_FROZEN: assert property (@(posedge cfgClk) disable iff (!rstN)
    memFull |=> $stable(lenCount)); // R4
endmodule

bind cfgChainLoader cfgChainLoader_chk uChk (
  .cfgClk      (cfgClk),
  .rstN        (rstN),
  .lenCount    (lenCount),
  .memFull     (memFull),
  .chainOut    (chainOut),
  .doneDriveLow(doneDriveLow),
  .hdrErr      (hdrErr)
);

// File: tb/sim_cfgChainLoader.sv
`timescale 1ns/1ps
module sim_cfgChainLoader;
  localparam int unsigned MEM_BYTES = 16;
  localparam int unsigned STARTUP   = 5;
  localparam int unsigned AW        = $clog2(MEM_BYTES);

  logic          cfgClk = 1'b0;
  logic          rstN, oscTick, initHigh, selIn;
  logic [7:0]    dataIn;
  logic [AW-1:0] rdAddr;
  logic [7:0]    rdData;
  logic [23:0]   lenCount;
  logic          memFull, chainOut, doneDriveLow, hdrErr;

  int unsigned total = 0;
  int unsigned fails = 0;
  logic [7:0]  expMem [MEM_BYTES];

  always #5 cfgClk = ~cfgClk;

  cfgChainLoader #(.MEM_BYTES(MEM_BYTES), .TICK_DELAY(2), .STARTUP_CYCLES(STARTUP)) u0 (
    .cfgClk(cfgClk), .rstN(rstN), .oscTick(oscTick), .initHigh(initHigh),
    .selIn(selIn), .dataIn(dataIn), .rdAddr(rdAddr), .rdData(rdData),
    .lenCount(lenCount), .memFull(memFull), .chainOut(chainOut),
    .doneDriveLow(doneDriveLow), .hdrErr(hdrErr)
  );

  function automatic logic [7:0] hdrByte(input int idx, input logic [23:0] len);
    case (idx)
      0, 5:    return 8'hFF;
      1:       return 8'hF2;
      2:       return len[23:16];
      3:       return len[15:8];
      default: return len[7:0];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic edgeIn(input logic sel, input logic [7:0] d, input logic tick);
    selIn = sel; dataIn = d; oscTick = tick;
    @(posedge cfgClk); #1;
    oscTick = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge cfgClk);
    #1;
    chk("R1", "chainOut in reset", chainOut, 1);
    chk("R1", "doneDriveLow in reset", doneDriveLow, 1);
    chk("R1", "hdrErr in reset", hdrErr, 0);
    chk("R1", "memFull in reset", memFull, 0);
    rstN = 1'b1;
  endtask

  // badIdx = 6 means a clean header
  task automatic sendHeader(input logic sel, input logic [23:0] len, input int badIdx,
                            input logic [7:0] badVal);
    initHigh = 1'b1;
    edgeIn(sel, 8'h00, 1'b0);
    chk("R3", "start edge does not sample", hdrErr, 0);
    for (int i = 0; i < 6; i++) begin
      edgeIn(sel, (i == badIdx) ? badVal : hdrByte(i, len), (i == 0 || i == 2));
      if (i == badIdx) begin
        chk("R9", "hdrErr on bad constant", hdrErr, 1);
        return;
      end
      if (i == 0) chk("R2", "chainOut after first tick", chainOut, 1);
      if (i == 2) chk("R2", "chainOut after second tick", chainOut, 0);
    end
    chk("R4", "lenCount parsed", lenCount, {8'h0, len});
    chk("R5", "no error regardless of select", hdrErr, 0);
  endtask

  task automatic readBack(input string req);
    for (int a = 0; a < MEM_BYTES; a++) begin
      rdAddr = AW'(a); #1;
      chk(req, $sformatf("mem[%0d]", a), rdData, expMem[a]);
    end
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int written;
    logic s;
    logic [7:0] d;
    void'($urandom(32'h5eed_c0de));
    rstN = 0; oscTick = 0; initHigh = 0; selIn = 0; dataIn = 0; rdAddr = 0;
    doReset();

    // R3: header-looking bytes while init low are ignored
    edgeIn(1'b1, 8'hFF, 1'b1);
    edgeIn(1'b1, 8'hF2, 1'b1);
    chk("R3", "no action before init", hdrErr, 0);
    chk("R3", "chainOut before init", chainOut, 1);

    // run 1: header unselected, short length count unrelated to depth
    sendHeader(1'b0, 24'h000004, 6, 8'h00);
    written = 0;
    edgeIn(1'b0, 8'hAA, 1'b0);  // R6 directed: unselected byte dropped
    while (written < MEM_BYTES) begin
      s = ($urandom % 3) != 0;
      d = 8'($urandom);
      edgeIn(s, d, 1'b0);
      if (s) begin expMem[written] = d; written++; end
      chk("R7", "memFull", memFull, written == MEM_BYTES);
      chk("R7", "chainOut", chainOut, written == MEM_BYTES);
      chk("R8", "done held during load", doneDriveLow, 1);
    end
    for (int k = 1; k <= STARTUP; k++) begin
      edgeIn(1'b1, 8'($urandom), 1'b0);  // R7: extra bytes must be dropped
      chk("R8", $sformatf("done at start-up edge %0d", k), doneDriveLow, k < STARTUP);
    end
    readBack("R6");

    // run 2: bad sync byte
    doReset();
    sendHeader(1'b1, 24'h00ABCD, 1, 8'hF3);
    for (int k = 0; k < 24; k++) begin
      edgeIn(1'b1, 8'($urandom), 1'b0);
      if (k % 6 == 5) begin
        chk("R9", "hdrErr sticky", hdrErr, 1);
        chk("R9", "done held low", doneDriveLow, 1);
        chk("R9", "no fill after error", memFull, 0);
      end
    end
    readBack("R9");

    // run 3: bad trailing fill byte
    doReset();
    sendHeader(1'b1, 24'h000010, 5, 8'h00);
    edgeIn(1'b1, 8'h11, 1'b0);
    readBack("R9");

    // run 4: selected throughout, directed pattern, full length count
    doReset();
    sendHeader(1'b1, 24'hFFFFFF, 6, 8'h00);
    for (int a = 0; a < MEM_BYTES; a++) begin
      expMem[a] = 8'(a * 7 + 3);
      edgeIn(1'b1, expMem[a], 1'b0);
    end
    chk("R7", "memFull after last byte", memFull, 1);
    chk("R7", "chainOut after last byte", chainOut, 1);
    edgeIn(1'b1, 8'h5A, 1'b0);
    readBack("R7");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule